// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a 64-bit integer ALU that treats each operand as a row of independent lanes and applies one operation to every lane in the same cycle. A two-bit lane mode cuts the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. No carry or borrow crosses a lane boundary.

The opcode selects one of these operations:

- wrapping add or subtract;
- clamping add or subtract;
- a bitwise logic operation over the full word;
- a narrowing pack with saturation;
- a widening unpack that interleaves the elements of the two operands.

A signed/unsigned flag picks the clamp range for the clamping operations and for pack.

Each valid request produces a registered result one clock later, together with a matching valid strobe. The result register keeps its value while no request is presented.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `valid_out` becomes 0 and `result` becomes all zeros.
- R2: `valid_out` equals the previous cycle's `valid_in`. A request presented at edge k appears on `result` after edge k. When `valid_in` is low, `result` keeps its value.
- R3: `mode` encodes the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Opcode 0 adds and opcode 1 subtracts (A minus B) modulo the lane width. No carry or borrow passes between lanes.
- R4: Opcode 2 adds each lane with clamping. Signed lanes clamp to [-2^(w-1), 2^(w-1)-1]. Unsigned lanes clamp to [0, 2^w-1].
- R5: Opcode 3 subtracts A minus B in each lane with the same clamp ranges as R4. An unsigned result below zero becomes 0.
- R6: In 64-bit mode, opcodes 2 and 3 clamp to the full 64-bit signed or unsigned range.
- R7: Opcodes 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and (NOT A) AND B over all 64 bits. The lane mode has no effect on them.
- R8: Opcode 8 (pack) reads source lanes of width 8<<mode, for modes 1 to 3, as signed values and narrows them to half width. Signed pack clamps to the signed half-width range. Unsigned pack clamps to [0, 2^(w/2)-1]. The lanes from A fill the low 32 bits in lane order, and the lanes from B fill the high 32 bits.
- R9: Opcode 9 (unpack low) takes element width 8<<mode for modes 0 to 2. For each i below half the lane count, output lane 2i = A lane i and output lane 2i+1 = B lane i.
- R10: Opcode 10 (unpack high) works like R9 but takes A and B lanes from the upper half: output lane 2i = A lane (n/2+i) and output lane 2i+1 = B lane (n/2+i).
- R11: Opcodes 11 to 15, pack in mode 0 and unpack in mode 3 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe |
| opcode | input | 4 | Operation select |
| mode | input | 2 | Lane width select |
| is_signed | input | 1 | 1 = signed clamp ranges |
| src_a | input | 64 | Operand A |
| src_b | input | 64 | Operand B |
| valid_out | output | 1 | Result strobe, one cycle after `valid_in` |
| result | output | 64 | Registered result |

## Verification
The bench builds the block with its default word width of 64. This makes all four lane partitions reachable, including the single 64-bit lane where clamping spans the whole word. With this width, pack covers three source widths (16, 32 and 64 bits) and unpack covers three element widths (8, 16 and 32 bits). Lane-boundary carries are exercised by an operand pair whose carry would ripple through 32 bits in every mode.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int DATA_W = 64;
    localparam int OP_W   = 4;
    localparam int MODE_W = 2;
    localparam int NUM_MODES = 4;

    typedef enum logic [MODE_W-1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_mode_e;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADDS = 4'd2,
        OP_SUBS = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_ANDN = 4'd7,
        OP_PACK = 4'd8,
        OP_UNPL = 4'd9,
        OP_UNPH = 4'd10
    } alu_op_e;

    typedef struct packed {
        alu_op_e           op;
        lane_mode_e        mode;
        logic              is_signed;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } alu_req_t;

    function automatic logic op_is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBS);
    endfunction

    function automatic logic op_is_sat(alu_op_e op);
        return (op == OP_ADDS) || (op == OP_SUBS);
    endfunction

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          sat,
    input  logic          is_signed,
    input  lane_mode_e    mode,
    output logic [DW-1:0] y
);

    logic [NUM_MODES-1:0][DW-1:0] parts;

    for (genvar w = 0; w < NUM_MODES; w++) begin : g_width
        localparam int LW = 8 << w;
        localparam int NL = DW / LW;
        logic [DW-1:0] part;

        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] la, lb, lr;
            logic [LW:0]   ex_a, ex_b, s;

            assign la   = a[l*LW +: LW];
            assign lb   = b[l*LW +: LW];
            assign ex_a = {is_signed & la[LW-1], la};
            assign ex_b = {is_signed & lb[LW-1], lb};
            assign s    = sub ? (ex_a - ex_b) : (ex_a + ex_b);

            always_comb begin
                lr = s[LW-1:0];
                if (sat) begin
                    if (is_signed) begin
                        if (s[LW] != s[LW-1]) begin
                            lr = s[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
                        end
                    end else if (s[LW]) begin
                        lr = sub ? '0 : '1;
                    end
                end
            end

            assign part[l*LW +: LW] = lr;
        end

        assign parts[w] = part;
    end

    assign y = parts[mode];

endmodule

// File: rtl/simd_logic.sv
module simd_logic
    import simd_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ANDN: y = ~a & b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_pack.sv
module simd_pack
    import simd_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          is_signed,
    input  logic          high,
    input  lane_mode_e    mode,
    output logic [DW-1:0] pack_y,
    output logic [DW-1:0] unpack_y
);

    logic [NUM_MODES-1:0][DW-1:0] pk;
    logic [NUM_MODES-1:0][DW-1:0] up_lo;
    logic [NUM_MODES-1:0][DW-1:0] up_hi;

    // Narrowing: mode k names the source width 8<<k; k = 0 has no half width
    assign pk[0] = '0;
    for (genvar k = 1; k < NUM_MODES; k++) begin : g_pack
        localparam int SW = 8 << k;
        localparam int HW = SW / 2;
        localparam int NS = DW / SW;
        logic [DW-1:0] pv;

        for (genvar o = 0; o < 2; o++) begin : g_opnd
            for (genvar s = 0; s < NS; s++) begin : g_src
                logic [SW-1:0] v;
                logic [HW:0]   top;
                logic [HW-1:0] n;

                assign v   = (o == 0) ? a[s*SW +: SW] : b[s*SW +: SW];
                assign top = v[SW-1:HW-1];

                always_comb begin
                    if (is_signed) begin
                        if ((&top) || !(|top)) n = v[HW-1:0];
                        else n = v[SW-1] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}};
                    end else begin
                        if (v[SW-1])          n = '0;
                        else if (|v[SW-2:HW]) n = '1;
                        else                  n = v[HW-1:0];
                    end
                end

                assign pv[(o*NS + s)*HW +: HW] = n;
            end
        end

        assign pk[k] = pv;
    end

    // Widening: mode k names the element width 8<<k; the single 64-bit lane has no halves
    assign up_lo[NUM_MODES-1] = '0;
    assign up_hi[NUM_MODES-1] = '0;
    for (genvar k = 0; k < NUM_MODES-1; k++) begin : g_unpack
        localparam int EW = 8 << k;
        localparam int NE = DW / EW;
        localparam int HE = NE / 2;
        logic [DW-1:0] lo_v, hi_v;

        for (genvar i = 0; i < HE; i++) begin : g_elem
            assign lo_v[(2*i)*EW   +: EW] = a[i*EW +: EW];
            assign lo_v[(2*i+1)*EW +: EW] = b[i*EW +: EW];
            assign hi_v[(2*i)*EW   +: EW] = a[(HE+i)*EW +: EW];
            assign hi_v[(2*i+1)*EW +: EW] = b[(HE+i)*EW +: EW];
        end

        assign up_lo[k] = lo_v;
        assign up_hi[k] = hi_v;
    end

    assign pack_y   = pk[mode];
    assign unpack_y = high ? up_hi[mode] : up_lo[mode];

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [OP_W-1:0]   opcode,
    input  logic [MODE_W-1:0] mode,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              valid_out,
    output logic [DATA_W-1:0] result
);

    alu_req_t          req;
    logic [DATA_W-1:0] arith_y, logic_y, pack_y, unpack_y, nxt;
    logic              valid_q;
    logic [DATA_W-1:0] result_q;

    assign req.op        = alu_op_e'(opcode);
    assign req.mode      = lane_mode_e'(mode);
    assign req.is_signed = is_signed;
    assign req.a         = src_a;
    assign req.b         = src_b;

    simd_addsub #(.DW(DATA_W)) u_addsub (
        .a         (req.a),
        .b         (req.b),
        .sub       (op_is_sub(req.op)),
        .sat       (op_is_sat(req.op)),
        .is_signed (req.is_signed),
        .mode      (req.mode),
        .y         (arith_y)
    );

    simd_logic #(.DW(DATA_W)) u_logic (
        .op (req.op),
        .a  (req.a),
        .b  (req.b),
        .y  (logic_y)
    );

    simd_pack #(.DW(DATA_W)) u_pack (
        .a         (req.a),
        .b         (req.b),
        .is_signed (req.is_signed),
        .high      (req.op == OP_UNPH),
        .mode      (req.mode),
        .pack_y    (pack_y),
        .unpack_y  (unpack_y)
    );

    always_comb begin
        case (req.op)
            OP_ADD, OP_SUB, OP_ADDS, OP_SUBS:    nxt = arith_y;
            OP_AND, OP_OR, OP_XOR, OP_ANDN:      nxt = logic_y;
            OP_PACK:                             nxt = pack_y;
            OP_UNPL, OP_UNPH:                    nxt = unpack_y;
            default:                             nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= valid_in;
            if (valid_in) result_q <= nxt;
        end
    end

    assign valid_out = valid_q;
    assign result    = result_q;

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_in,
    input logic [OP_W-1:0]   opcode,
    input logic [MODE_W-1:0] mode,
    input logic              is_signed,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              valid_out,
    input logic [DATA_W-1:0] result
);

    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> (!valid_out && $stable(result)));

    p_and_word_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode == 4'd4) |=> (result == $past(src_a & src_b)));

    p_usat_add_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode == 4'd2 && mode == 2'd0 && !is_signed)
        |=> (result[7:0] >= $past(src_a[7:0])));

    p_usat_sub_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode == 4'd3 && mode == 2'd0 && !is_signed)
        |=> (result[7:0] <= $past(src_a[7:0])));

    p_unsupported_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode > 4'd10) |=> (result == '0));

endmodule

bind simd_alu simd_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .opcode    (opcode),
    .mode      (mode),
    .is_signed (is_signed),
    .src_a     (src_a),
    .src_b     (src_b),
    .valid_out (valid_out),
    .result    (result)
);

// File: tb/simd_alu_tb.sv
module simd_alu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [3:0]  opcode = '0;
    logic [1:0]  mode = '0;
    logic        is_signed = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        valid_out;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    simd_alu u_dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .opcode(opcode), .mode(mode),
        .is_signed(is_signed), .src_a(src_a), .src_b(src_b),
        .valid_out(valid_out), .result(result)
    );

    function automatic logic [63:0] lmask(int w);
        return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] lane(logic [63:0] v, int w, int i);
        return (v >> (i * w)) & lmask(w);
    endfunction

    function automatic logic signed [65:0] ext(logic [63:0] v, int w, bit sgn);
        logic signed [65:0] x;
        x = $signed({2'b00, v & lmask(w)});
        if (sgn && v[w-1]) x = x - (66'sd1 <<< w);
        return x;
    endfunction

    function automatic logic signed [65:0] clampv(logic signed [65:0] x, int w, bit sgn);
        logic signed [65:0] hi, lo;
        hi = sgn ? (66'sd1 <<< (w - 1)) - 66'sd1 : (66'sd1 <<< w) - 66'sd1;
        lo = sgn ? -(66'sd1 <<< (w - 1)) : 66'sd0;
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    function automatic logic [63:0] model(int op, int md, bit sgn, logic [63:0] a, logic [63:0] b);
        int w = 8 << md;
        int n = 64 / w;
        logic [63:0] y = '0;
        logic signed [65:0] s;
        case (op)
            0, 1: for (int i = 0; i < n; i++) begin
                      logic [63:0] r;
                      r = (op == 1) ? lane(a, w, i) - lane(b, w, i) : lane(a, w, i) + lane(b, w, i);
                      y |= (r & lmask(w)) << (i * w);
                  end
            2, 3: for (int i = 0; i < n; i++) begin
                      s = (op == 2) ? ext(lane(a, w, i), w, sgn) + ext(lane(b, w, i), w, sgn)
                                    : ext(lane(a, w, i), w, sgn) - ext(lane(b, w, i), w, sgn);
                      s = clampv(s, w, sgn);
                      y |= (s[63:0] & lmask(w)) << (i * w);
                  end
            4: y = a & b;
            5: y = a | b;
            6: y = a ^ b;
            7: y = ~a & b;
            8: if (md != 0) begin
                   for (int o = 0; o < 2; o++) begin
                       for (int i = 0; i < n; i++) begin
                           s = ext(lane(o == 0 ? a : b, w, i), w, 1'b1);
                           s = clampv(s, w / 2, sgn);
                           y |= (s[63:0] & lmask(w / 2)) << ((o * n + i) * (w / 2));
                       end
                   end
               end
            9, 10: if (md != 3) begin
                       for (int i = 0; i < n / 2; i++) begin
                           int base = (op == 10) ? n / 2 : 0;
                           y |= lane(a, w, base + i) << (2 * i * w);
                           y |= lane(b, w, base + i) << ((2 * i + 1) * w);
                       end
                   end
            default: y = '0;
        endcase
        return y;
    endfunction

    task automatic send(int op, int md, bit sgn, logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        valid_in  = 1'b1;
        opcode    = op[3:0];
        mode      = md[1:0];
        is_signed = sgn;
        src_a     = a;
        src_b     = b;
        exp_q.push_back(model(op, md, sgn, a, b));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        valid_in = 1'b0;
        opcode   = 4'd4;
        src_a    = '1;
        src_b    = '1;
    endtask

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: pops one expected item per result strobe
    always @(negedge clk) begin
        if (!rst && valid_out) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected strobe", result, '0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(result === e, t, result, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(valid_out === 1'b0, "R1 reset strobe", {63'd0, valid_out}, '0);
        check(result === '0, "R1 reset result", result, '0);

        // R3 wrapping, carries stop at lane edges
        for (int md = 0; md < 4; md++)
            send(0, md, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R3 add carry cut");
        send(0, 0, 0, 64'hFF01_7F80_0102_0304, 64'h0101_0180_FFFF_0001, "R3 add bytes");
        send(1, 1, 0, 64'h0000_1234_8000_0001, 64'h0001_1235_0001_0002, "R3 sub words");
        send(1, 2, 1, 64'h0000_0000_1234_5678, 64'h0000_0001_0000_0000, "R3 sub dwords");
        // R4 clamping add
        send(2, 0, 1, 64'h7F80_7F80_1020_8181, 64'h0101_FFFF_0102_FFFF, "R4 signed add bytes");
        send(2, 0, 0, 64'hFF80_7F01_00F0_1020, 64'h0180_7FFF_0020_0102, "R4 unsigned add bytes");
        send(2, 1, 1, 64'h7FFF_8000_1234_0001, 64'h0001_8000_0001_0001, "R4 signed add words");
        send(2, 2, 0, 64'hFFFF_FFF0_0000_0010, 64'h0000_0020_0000_0020, "R4 unsigned add dwords");
        // R5 clamping subtract
        send(3, 0, 0, 64'h0010_FF00_0102_0304, 64'h0020_0001_0201_0303, "R5 unsigned sub bytes");
        send(3, 1, 1, 64'h8000_7FFF_0005_FFFE, 64'h0001_FFFF_0007_0001, "R5 signed sub words");
        send(3, 2, 0, 64'h0000_0005_FFFF_FFFF, 64'h0000_0006_0000_0001, "R5 unsigned sub dwords");
        // R6 full-word clamps
        send(2, 3, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R6 signed add max");
        send(2, 3, 0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0100, "R6 unsigned add max");
        send(3, 3, 0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, "R6 unsigned sub floor");
        send(3, 3, 1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, "R6 signed sub min");
        // R7 logic, mode ignored
        send(4, 0, 1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1111_FFFF, "R7 and");
        send(5, 2, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1111_FFFF, "R7 or");
        send(6, 3, 1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1111_FFFF, "R7 xor");
        send(7, 1, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1111_FFFF, "R7 andn");
        // R8 pack
        send(8, 1, 1, 64'h0100_FF7F_FF80_0042, 64'h8000_7FFF_FFFF_0001, "R8 signed pack words");
        send(8, 1, 0, 64'h0100_FF7F_00FF_0042, 64'h8000_7FFF_0080_0001, "R8 unsigned pack words");
        send(8, 2, 1, 64'hFFFF_0000_0000_8000, 64'h0000_1234_FFFF_FFFE, "R8 signed pack dwords");
        send(8, 3, 0, 64'h0000_0000_DEAD_BEEF, 64'hFFFF_FFFF_FFFF_FFFF, "R8 unsigned pack qword");
        send(8, 3, 1, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_8000_0000, "R8 signed pack qword");
        // R9 and R10 unpack
        for (int md = 0; md < 3; md++) begin
            send(9,  md, 0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, "R9 unpack low");
            send(10, md, 1, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, "R10 unpack high");
        end
        // R11 unsupported
        send(12, 1, 0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R11 undefined opcode");
        send(8,  0, 1, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R11 pack bytes");
        send(9,  3, 0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R11 unpack qword");
        send(0,  2, 0, 64'h0000_0001_0000_0002, 64'h0000_0003_0000_0004, "R2 last request");
        idle();
        held = 64'h0000_0004_0000_0006;
        @(negedge clk);
        check(valid_out === 1'b0, "R2 strobe drops", {63'd0, valid_out}, '0);
        check(result === held, "R2 result held", result, held);
        repeat (2) @(negedge clk);
        check(result === held, "R2 result still held", result, held);
        check(exp_q.size() == 0, "R2 all results seen", 64'(exp_q.size()), '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule